// File: doc/BRIEF.md
# Grouped Edge Interrupt Vector Controller

This block gathers up to 256 edge-triggered interrupt sources and sorts them into groups of 32 vectors. A rising edge on a source sets a sticky pending bit. A per-vector enable bit decides whether that pending bit can reach the group's parent interrupt line. Each group drives its own output line toward a parent interrupt controller.

Software uses a 32-bit register bus with byte addresses. It reads which vectors are pending and acknowledges them by writing ones. It masks or unmasks vectors by writing the enable words. The number of groups, `NGRP`, is a parameter from 1 to 8. Priority selection and vector numbering are left to software, which scans the pending words.

Top module: `evec_ctrl`

## Requirements
- R1: After reset, every pending word, every enable word and every `irq_o` bit read zero. The edge history is cleared, so a source that is already high when reset is released counts as a rising edge on the first clock.
- R2: The pending word for group i is at byte offset 4*i. Writing 1 to a bit clears that vector's pending state. Writing 0 to a bit leaves it unchanged.
- R3: If a new rising edge and a write-one-to-clear hit the same bit in the same cycle, the bit stays pending.
- R4: A 0-to-1 transition of a source sets its pending bit whether the vector is enabled or not. A source that stays high does not set the bit again after it is acknowledged.
- R5: A pending bit stays set until it is acknowledged, even after its source falls.
- R6: The enable word for group i is at byte offset 0x20 + 4*i. It reads back the last value written. Bit value 1 unmasks the vector and 0 masks it.
- R7: `irq_o[i]` is high exactly when pending AND enable of group i is nonzero. It is registered, so it follows a change one cycle later. A group whose enable word is zero never raises its line.
- R8: Source n belongs to group n/32 at bit position n%32. Groups do not affect one another.
- R9: The following accesses read zero and their writes are ignored:
  - offsets that are not word aligned;
  - offsets of groups at or beyond `NGRP`;
  - offsets outside the two word ranges.
- R10: Writing zero to every enable word and all ones to every pending word leaves the block fully masked, with nothing pending and every `irq_o` bit low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| src_i | input | NGRP*32 | Edge-triggered interrupt sources |
| bus_addr_i | input | ADDR_W | Byte address of the register access |
| bus_we_i | input | 1 | Write strobe, taken at the rising clock edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | NGRP | One parent interrupt line per group |

## Verification
The assertions check the following on every cycle:
- a new edge always leaves its bit set (R3);
- an acknowledged bit with no new edge is cleared (R2);
- no pending bit drops without a clear (R5);
- enable words change only on a write (R6);
- a fully masked group keeps its line low (R7);
- unmapped reads return zero and unmapped writes leave the enables untouched (R9).

Only the bench scenarios can show the rest:
- the address-to-group mapping of specific vectors (R8);
- that a held-high source does not fire again (R4);
- the exact one-cycle lag of the output lines (R7);
- the full masking sequence at start-up (R10).

// File: rtl/evec_pkg.sv
package evec_pkg;
  localparam int unsigned VEC_PER_GRP = 32;
  localparam int unsigned MAX_GRP     = 8;
  localparam int unsigned EN_BASE     = 32'h20;
  localparam int unsigned WORD_BYTES  = 4;
  typedef logic [VEC_PER_GRP-1:0] vec_word_t;
endpackage

// File: rtl/evec_edge.sv
module evec_edge #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] hist_q;
  logic [W-1:0] hist_d;

  always_comb begin
    hist_d = src_i;
    rise_o = src_i & ~hist_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end
endmodule

// File: rtl/evec_group.sv
module evec_group
  import evec_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  vec_word_t rise_i,
  input  vec_word_t clr_i,
  input  logic      en_we_i,
  input  vec_word_t wdata_i,
  output vec_word_t pend_o,
  output vec_word_t en_o,
  output logic      irq_o
);
  vec_word_t pend_q, pend_d;
  vec_word_t en_q, en_d;
  logic      irq_q, irq_d;

  always_comb begin
    pend_d = (pend_q & ~clr_i) | rise_i;
    en_d   = wdata_i;
    irq_d  = |(pend_q & en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (en_we_i) en_q <= en_d;
      irq_q  <= irq_d;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign irq_o  = irq_q;

  a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_i) |=> ((pend_q & $past(rise_i)) == $past(rise_i)));
  a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~rise_i)) |=> ((pend_q & $past(clr_i & ~rise_i)) == '0));
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_q) |=> (($past(pend_q) & ~pend_q & ~$past(clr_i)) == '0));
  a_r6_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we_i |=> $stable(en_q));
  a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |=> !irq_o);
endmodule

// File: rtl/evec_regif.sv
module evec_regif
  import evec_pkg::*;
#(
  parameter int unsigned NGRP   = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic                         we_i,
  input  vec_word_t                    wdata_i,
  input  logic [NGRP-1:0][VEC_PER_GRP-1:0] pend_i,
  input  logic [NGRP-1:0][VEC_PER_GRP-1:0] en_i,
  output logic [NGRP-1:0][VEC_PER_GRP-1:0] pend_clr_o,
  output logic [NGRP-1:0]              en_we_o,
  output vec_word_t                    rdata_o
);
  localparam int unsigned IDX_LSB = 2;
  localparam int unsigned REG_LSB = 5;

  logic       aligned;
  logic [2:0] idx;
  logic       in_range;
  logic       hit_pend, hit_en;

  always_comb begin
    aligned  = (addr_i[1:0] == 2'b00);
    idx      = addr_i[REG_LSB-1:IDX_LSB];
    in_range = (int'(idx) < NGRP);
    hit_pend = aligned && in_range && (int'(addr_i >> REG_LSB) == 0);
    hit_en   = aligned && in_range && (int'(addr_i >> REG_LSB) == int'(EN_BASE >> REG_LSB));
    rdata_o    = '0;
    pend_clr_o = '0;
    en_we_o    = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (int'(idx) == g) begin
        if (hit_pend) begin
          rdata_o       = pend_i[g];
          pend_clr_o[g] = we_i ? wdata_i : '0;
        end
        if (hit_en) begin
          rdata_o    = en_i[g];
          en_we_o[g] = we_i;
        end
      end
    end
  end
endmodule

// File: rtl/evec_ctrl.sv
module evec_ctrl
  import evec_pkg::*;
#(
  parameter int unsigned NGRP   = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NGRP*VEC_PER_GRP-1:0] src_i,
  input  logic [ADDR_W-1:0]           bus_addr_i,
  input  logic                        bus_we_i,
  input  logic [31:0]                 bus_wdata_i,
  output logic [31:0]                 bus_rdata_o,
  output logic [NGRP-1:0]             irq_o
);
  localparam int unsigned NSRC = NGRP * VEC_PER_GRP;

  logic [NSRC-1:0]                     rise;
  logic [NGRP-1:0][VEC_PER_GRP-1:0]    pend_w, en_w, clr_w;
  logic [NGRP-1:0]                     en_we_w;

  evec_edge #(.W(NSRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .rise_o(rise)
  );

  evec_regif #(.NGRP(NGRP), .ADDR_W(ADDR_W)) u_regif (
    .addr_i(bus_addr_i), .we_i(bus_we_i), .wdata_i(bus_wdata_i),
    .pend_i(pend_w), .en_i(en_w), .pend_clr_o(clr_w),
    .en_we_o(en_we_w), .rdata_o(bus_rdata_o)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    evec_group u_grp (
      .clk(clk), .rst_n(rst_n),
      .rise_i(rise[g*VEC_PER_GRP +: VEC_PER_GRP]),
      .clr_i(clr_w[g]), .en_we_i(en_we_w[g]), .wdata_i(bus_wdata_i),
      .pend_o(pend_w[g]), .en_o(en_w[g]), .irq_o(irq_o[g])
    );
  end

  // Address classification computed from the port value, for the R9 checks
  logic mapped_pend, mapped_en;
  always_comb begin
    mapped_pend = (int'(bus_addr_i) % WORD_BYTES == 0) &&
                  (int'(bus_addr_i) < int'(NGRP * WORD_BYTES));
    mapped_en   = (int'(bus_addr_i) % WORD_BYTES == 0) &&
                  (int'(bus_addr_i) >= int'(EN_BASE)) &&
                  (int'(bus_addr_i) < int'(EN_BASE + NGRP * WORD_BYTES));
  end

  a_r9_rd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(mapped_pend || mapped_en) |-> (bus_rdata_o == '0));
  a_r9_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we_i && !mapped_en) |=> $stable(en_w));
endmodule

// File: tb/evec_ctrl_bench.sv
`timescale 1ns/1ps
module evec_ctrl_bench;
  localparam int NGRP = 4;
  localparam int NSRC = NGRP * 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NSRC-1:0]   src;
  logic [7:0]        addr;
  logic              we;
  logic [31:0]       wdata;
  logic [31:0]       rdata;
  logic [NGRP-1:0]   irq;

  evec_ctrl #(.NGRP(NGRP), .ADDR_W(8)) u_evec_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr_i(addr),
    .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    mon_act = 1'b0;
  bit    done = 1'b0;

  // monitor: pops one expected item per active cycle, compares at negedge
  always @(negedge clk) begin
    item_t it;
    logic [31:0] act;
    if (mon_act && sbq.size() > 0) begin
      it  = sbq.pop_front();
      act = it.is_irq ? {{(32-NGRP){1'b0}}, irq} : rdata;
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic push_cmp(bit is_irq, logic [7:0] a, logic [31:0] e, string tag);
    item_t it;
    @(posedge clk); #1;
    addr = a;
    it.is_irq = is_irq; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    mon_act = 1'b1;
    @(posedge clk); #1;
    mon_act = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, string tag);
    push_cmp(1'b0, a, e, tag);
  endtask

  task automatic chk_irq(logic [31:0] e, string tag);
    push_cmp(1'b1, 8'h00, e, tag);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic pulse(int n);
    @(posedge clk); #1;
    src[n] = 1'b1;
    @(posedge clk); #1;
    src[n] = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src = '0; addr = '0; we = 1'b0; wdata = '0;
    src[1] = 1'b1;                       // held high across reset release
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state; history cleared so held source is captured once
    rd(8'h00, 32'h0000_0002, "R1 pend0 captures source high at release");
    for (int g = 1; g < NGRP; g++) rd(8'(4*g), 32'h0, "R1 pend reset");
    for (int g = 0; g < NGRP; g++) rd(8'(8'h20 + 4*g), 32'h0, "R1 en reset");
    chk_irq(32'h0, "R1 irq reset");
    // R4: held-high source does not retrigger after ack
    wr(8'h00, 32'h0000_0002);
    rd(8'h00, 32'h0, "R4 held source no retrigger after ack");
    src[1] = 1'b0;

    // R4/R8: vector 37 -> group 1 bit 5, captured while masked
    pulse(37);
    rd(8'h04, 32'h0000_0020, "R8 vector 37 in group1 bit5");
    rd(8'h00, 32'h0, "R8 group0 untouched");
    chk_irq(32'h0, "R7 masked group stays low");

    // R6/R7: unmask
    wr(8'h24, 32'h0000_0020);
    rd(8'h24, 32'h0000_0020, "R6 en1 readback");
    chk_irq(32'h2, "R7 irq1 after unmask");

    // R2: zeros do nothing, ones clear
    wr(8'h04, 32'hFFFF_FFDF);
    rd(8'h04, 32'h0000_0020, "R2 zero bit leaves pending");
    wr(8'h04, 32'h0000_0020);
    rd(8'h04, 32'h0, "R2 write one clears");
    chk_irq(32'h0, "R7 irq1 drops after ack");

    // R5/R8: sticky after source falls, extreme vectors
    pulse(127);
    pulse(0);
    rd(8'h0C, 32'h8000_0000, "R5 vector 127 sticky in group3 bit31");
    rd(8'h00, 32'h0000_0001, "R5 vector 0 sticky");
    wr(8'h2C, 32'h8000_0000);
    chk_irq(32'h8, "R7 irq3 only");

    // R3: edge and clear in the same cycle on vector 64
    @(posedge clk); #1;
    src[64] = 1'b1; addr = 8'h08; wdata = 32'h0000_0001; we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0;
    rd(8'h08, 32'h0000_0001, "R3 set wins over clear");
    wr(8'h08, 32'h0000_0001);
    rd(8'h08, 32'h0, "R3 later clear with source held");
    src[64] = 1'b0;

    // R9: unmapped and out-of-range accesses
    wr(8'h34, 32'hFFFF_FFFF);
    rd(8'h34, 32'h0, "R9 en beyond NGRP reads zero");
    rd(8'h14, 32'h0, "R9 pend beyond NGRP reads zero");
    rd(8'h40, 32'h0, "R9 unmapped offset reads zero");
    wr(8'h22, 32'hFFFF_FFFF);
    rd(8'h21, 32'h0, "R9 misaligned read zero");
    rd(8'h20, 32'h0, "R9 misaligned write ignored");
    rd(8'h2C, 32'h8000_0000, "R9 en3 unchanged");

    // R10: init sequence
    for (int g = 0; g < NGRP; g++) begin
      wr(8'(8'h20 + 4*g), 32'h0);
      wr(8'(4*g), 32'hFFFF_FFFF);
    end
    for (int g = 0; g < NGRP; g++) begin
      rd(8'(4*g), 32'h0, "R10 nothing pending");
      rd(8'(8'h20 + 4*g), 32'h0, "R10 all masked");
    end
    chk_irq(32'h0, "R10 no irq");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule